// File: doc/BRIEF.md
# Bit-serial two's complement subtractor

This block subtracts one signed two's complement operand from another using a single one-bit full adder over several clock cycles. It computes the difference as A plus the bitwise inverse of B, plus one. The datapath has two right-shifting operand registers, an inverter on the B register's low bit and a one-bit full adder. A carry flip-flop holds the carry from one bit to the next. It is preset to 1 when the operands load, and that preset supplies the +1.

A start strobe in idle launches one operation. A small controller first spends one cycle loading both operands and presetting the carry. It then spends WIDTH cycles shifting. In each shift cycle the adder's sum bit enters the A register from the MSB side, so the difference ends up in the A register. The carry-in and carry-out of the sign-bit addition are compared in the last shift cycle to form a signed overflow flag. That flag is registered and holds until the next operation loads. The block then returns to idle, where it waits for the next start.

Top module: `serial_sub`

## Requirements
- R1: After reset, busy_o, done_o and ovf_o are 0 and diff_o is all zeros.
- R2: A start_i of 1 sampled on a clock edge while idle makes busy_o 1 from that edge for exactly WIDTH+1 cycles. On the edge that clears busy_o, done_o rises for exactly one cycle.
- R3: When done_o is 1, diff_o equals (a_i - b_i) modulo 2^WIDTH. Both operands are unsigned bit patterns of two's complement numbers.
- R4: When done_o is 1, ovf_o is 1 exactly when the signed difference a_i - b_i falls outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. ovf_o keeps that value until the next operation's load edge, where it clears.
- R5: start_i is ignored while busy_o is 1. No extra operation starts and the busy length is unchanged. Changes on a_i and b_i after the load edge do not affect the result.
- R6: The operands are captured on the clock edge that ends the first busy cycle (the load cycle).
- R7: While idle, diff_o and ovf_o hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only in idle |
| a_i | input | WIDTH | Minuend, two's complement |
| b_i | input | WIDTH | Subtrahend, two's complement |
| diff_o | output | WIDTH | Difference, held in the A register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Signed overflow of the last operation |

## Verification
The bench builds the block with WIDTH = 4. At that width every one of the 256 operand pairs can be run, so both overflow directions and the -8 minus -8 and 7 minus -8 extremes are all exercised. One further run changes the operands and pulses start in the middle of shifting, to show that the result and the cycle count do not move.

// File: rtl/serial_sub_pkg.sv
package serial_sub_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } sub_state_e;
endpackage

// File: rtl/sub_full_adder.sv
// One-bit full adder built from a 3-to-8 active-low decode and two NAND terms.
module sub_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic cout_o
);
  logic [7:0] dec_n;

  for (genvar i = 0; i < 8; i++) begin : g_dec
    assign dec_n[i] = !({a_i, b_i, c_i} == 3'(i));
  end

  assign sum_o  = ~(dec_n[1] & dec_n[2] & dec_n[4] & dec_n[7]);
  assign cout_o = ~(dec_n[3] & dec_n[5] & dec_n[6] & dec_n[7]);
endmodule

// File: rtl/sub_shift_reg.sv
// en=1 ld=1: parallel load, en=1 ld=0: shift right with ser_i into MSB, en=0: hold.
module sub_shift_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o,
  output logic             lsb_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (en_i) q_q <= ld_i ? par_i : {ser_i, q_q[WIDTH-1:1]};
  end

  assign q_o   = q_q;
  assign lsb_o = q_q[0];

  p_shift_right_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i) |=> (q_q[WIDTH-2:0] == $past(q_q[WIDTH-1:1])));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_q));
endmodule

// File: rtl/sub_ctrl.sv
module sub_ctrl
  import serial_sub_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic en_o,
  output logic ld_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(WIDTH - 1);

  sub_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_LOAD;
      ST_LOAD: begin
        state_d = ST_SHIFT;
        cnt_d   = '0;
      end
      ST_SHIFT: begin
        if (cnt_q == LAST_BIT) state_d = ST_IDLE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= last_o;
    end
  end

  assign en_o   = (state_q != ST_IDLE);
  assign ld_o   = (state_q == ST_LOAD);
  assign last_o = (state_q == ST_SHIFT) && (cnt_q == LAST_BIT);
  assign busy_o = en_o;
  assign done_o = done_q;

  p_start_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_LOAD));

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && start_i) |=> (state_q != ST_LOAD));
endmodule

// File: rtl/serial_sub.sv
module serial_sub #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] diff_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o
);
  logic en, ld, last;
  logic a_lsb, b_lsb, sum, cout;
  logic carry_q, ovf_q;
  logic [WIDTH-1:0] a_q, b_q;

  sub_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .en_o    (en),
    .ld_o    (ld),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  sub_shift_reg #(.WIDTH(WIDTH)) u_reg_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .ld_i   (ld),
    .par_i  (a_i),
    .ser_i  (sum),
    .q_o    (a_q),
    .lsb_o  (a_lsb)
  );

  // B fills with zeros; its contents after the operation are not used.
  sub_shift_reg #(.WIDTH(WIDTH)) u_reg_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .ld_i   (ld),
    .par_i  (b_i),
    .ser_i  (1'b0),
    .q_o    (b_q),
    .lsb_o  (b_lsb)
  );

  sub_full_adder u_fa (
    .a_i    (a_lsb),
    .b_i    (~b_lsb),
    .c_i    (carry_q),
    .sum_o  (sum),
    .cout_o (cout)
  );

  // Preset to 1 on load supplies the +1 of the two's complement.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        carry_q <= 1'b0;
    else if (en && ld)  carry_q <= 1'b1;
    else if (en)        carry_q <= cout;
  end

  // Sign-bit carry-in xor carry-out, captured in the last shift cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (en && ld)  ovf_q <= 1'b0;
    else if (last)      ovf_q <= carry_q ^ cout;
  end

  assign diff_o = a_q;
  assign ovf_o  = ovf_q;

  p_carry_preset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && ld) |=> carry_q);

  p_load_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && ld) |=> (a_q == $past(a_i) && b_q == $past(b_i)));

  p_ovf_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ovf_q) |-> (done_o || $past(ld)));

  p_diff_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(diff_o));
endmodule

// File: tb/serial_sub_bench.sv
module serial_sub_bench;
  localparam int unsigned W   = 4;
  localparam int          MAXV = (1 << (W - 1)) - 1;
  localparam int          MINV = -(1 << (W - 1));

  typedef struct packed {
    logic [W-1:0] d;
    logic         o;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] diff_o;
  logic         busy_o, done_o, ovf_o;

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  exp_t sb_q[$];

  serial_sub #(.WIDTH(W)) u_serial_sub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .diff_o  (diff_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .ovf_o   (ovf_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int to_signed(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Monitor: compare each completion against the scoreboard.
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(diff_o == e.d, "R3 diff", int'(diff_o), int'(e.d));
        check(ovf_o == e.o, "R4 ovf", int'(ovf_o), int'(e.o));
      end
    end
  end

  // Driver: push expected result and run one operation.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit noisy);
    exp_t e;
    int   sd, n;
    logic [W-1:0] d_hold;
    logic         o_hold;
    sd  = to_signed(a) - to_signed(b);
    e.d = W'(a - b);
    e.o = (sd > MAXV) || (sd < MINV);
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    start_i = 1'b1;
    sb_q.push_back(e);
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    n = 0;
    while (busy_o) begin
      n++;
      if (noisy && n == 2) begin
        // R5: operands change and start pulses after the load edge
        a_i = ~a;
        b_i = ~b;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(n == W + 1, noisy ? "R5 busy length" : "R2 busy length", n, W + 1);
    check(done_o == 1'b1, "R2 done at busy fall", int'(done_o), 1);
    d_hold = diff_o;
    o_hold = ovf_o;
    @(negedge clk_i);
    check(done_o == 1'b0, "R2 done one cycle", int'(done_o), 0);
    check(diff_o == d_hold, "R7 diff held", int'(diff_o), int'(d_hold));
    check(ovf_o == o_hold, "R7 ovf held", int'(ovf_o), int'(o_hold));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    check(done_o == 1'b0, "R1 done", int'(done_o), 0);
    check(ovf_o == 1'b0, "R1 ovf", int'(ovf_o), 0);
    check(diff_o == '0, "R1 diff", int'(diff_o), 0);

    // R4 corners: positive and negative overflow, then a clean case clears it
    run_op(W'(7), W'(8), 1'b0);
    run_op(W'(8), W'(1), 1'b0);
    run_op(W'(8), W'(8), 1'b0);

    // R6: operands set together with start are the ones used
    run_op(W'(5), W'(3), 1'b0);

    // R5: start and operand changes while busy
    run_op(W'(2), W'(6), 1'b1);
    run_op(W'(7), W'(15), 1'b1);

    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_op(W'(a), W'(b), 1'b0);
      end
    end

    repeat (2) @(negedge clk_i);
    check(sb_q.size() == 0, "R2 all results seen", sb_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule